// File: doc/BRIEF.md
# DS3 Receive Alarm Interrupt Controller

This block sits behind a DS3 receive framer and turns its per-frame status and defect levels into what a microprocessor reads: a status byte, an interrupt enable byte, a set of sticky interrupt flags and one interrupt line. The framer supplies a strobe at each M-frame boundary together with the received AIC bit and FEBE triplet. It also supplies single-cycle CP-bit and P-bit error pulses and level indicators for loss of signal, alarm indication signal, idle, remote defect (FERF/RDI) and out of frame.

The AIC bit passes through an asymmetric persistence filter. Two consecutive frames with AIC low bring the reported state down, and 63 consecutive frames with AIC high bring it up. The FEBE value of the latest frame is held for reading. Each defect level raises an interrupt on every change, in both directions. The CP-bit error source and the FEBE field depend on the C-bit parity framing select. Interrupt flags are latched only for enabled sources, they stay set until a read strobe clears them, and an event that arrives in the same cycle as that read is kept.

Top module: `ds3_rx_alarm_irq`

## Requirements
- R1: The reported AIC state (status bit 3) changes from 1 to 0 only at the end of the second consecutive M-frame that carries AIC = 0. A single zero frame, or two zero frames with a one frame between them, leaves it at 1.
- R2: The reported AIC state changes from 0 to 1 only at the end of the 63rd consecutive M-frame that carries AIC = 1. Any zero frame restarts the count.
- R3: In C-bit parity mode (cbit_mode = 1), status bits 2:0 hold the FEBE triplet of the most recent M-frame. When cbit_mode = 0 they read 3'b111, and frames received in that mode do not change the held value.
- R4: Status bit 4 follows the rdi input. Status bits 7:5 read 0.
- R5: Each defect level raises its interrupt flag on both its rising and its falling edge. The flag positions are LOS = bit 6, AIS = bit 5, idle = bit 4, FERF/RDI = bit 3 and OOF = bit 1.
- R6: A cp_err pulse sets flag bit 7 only when cbit_mode = 1. A p_err pulse sets flag bit 0 in either mode.
- R7: Every change of the reported AIC state, in either direction, sets flag bit 2.
- R8: The enable byte resets to 0x00 and loads ien_wdata when ien_wr = 1. It uses the same bit positions as the flags. A source event whose enable bit is 0 is not latched.
- R9: Flags stay set until an isr_rd strobe clears them. An event that arrives in the same cycle as the strobe remains set after the clear.
- R10: irq is 1 exactly when some flag bit and its enable bit are both 1.
- R11: After reset the status byte reads 0x07 (with rdi = 0), the flags read 0x00 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbit_mode | input | 1 | 1 selects C-bit parity framing |
| mframe_stb | input | 1 | One-cycle M-frame boundary strobe; qualifies aic_bit and febe_bits |
| aic_bit | input | 1 | Received AIC bit of the frame |
| febe_bits | input | 3 | Received FEBE triplet of the frame |
| cp_err | input | 1 | CP-bit error pulse |
| p_err | input | 1 | P-bit error pulse |
| los | input | 1 | Loss-of-signal defect level |
| ais | input | 1 | AIS defect level |
| idle | input | 1 | Idle condition level |
| rdi | input | 1 | FERF/RDI defect level |
| oof | input | 1 | Out-of-frame defect level |
| ien_wr | input | 1 | Enable byte write strobe |
| ien_wdata | input | 8 | Enable byte write data |
| isr_rd | input | 1 | Flag read strobe; clears the flags |
| stat_byte | output | 8 | Read-only status byte |
| ien_byte | output | 8 | Current enable byte |
| isr_byte | output | 8 | Sticky interrupt flags |
| irq | output | 1 | Combined interrupt line |

## Verification
The AIC filter is driven with runs of exactly 62 and 63 high frames, single and paired low frames, and high runs broken by one low frame. These patterns separate a correct threshold from off-by-one counts and from a counter that fails to restart. Each defect level is raised and dropped on its own, which shows that both edges fire and that each lands on its own flag bit. The error pulses, the framing select, masked sources and a read that coincides with a new event then show gating, masking and the no-loss read rule. A long random phase with rare AIC flips and sparse pulses is compared every clock against a behavioural model.

// File: rtl/ds3_alm_pkg.sv
package ds3_alm_pkg;
    // interrupt flag / enable bit positions
    localparam int IB_PERR  = 0;
    localparam int IB_OOF   = 1;
    localparam int IB_AIC   = 2;
    localparam int IB_RDI   = 3;
    localparam int IB_IDLE  = 4;
    localparam int IB_AIS   = 5;
    localparam int IB_LOS   = 6;
    localparam int IB_CPERR = 7;
    localparam int IRQ_W    = 8;
    localparam int DEF_N    = 5;    // level defects: {los, ais, idle, rdi, oof}
    localparam logic [2:0] FEBE_OK = 3'b111;
endpackage

// File: rtl/ds3_aic_filter.sv
module ds3_aic_filter #(
    parameter int AIC_FALL = 2,
    parameter int AIC_RISE = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic bit_in,
    output logic state,
    output logic chg
);
    localparam int CNT_MAX = (AIC_RISE > AIC_FALL) ? AIC_RISE : AIC_FALL;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run_val;
        logic             state;
    } aic_st_t;

    aic_st_t q, d;

    always_comb begin
        d = q;
        if (stb) begin
            if (bit_in == q.run_val) begin
                if (q.cnt != CNT_W'(CNT_MAX))
                    d.cnt = q.cnt + CNT_W'(1);
            end else begin
                d.run_val = bit_in;
                d.cnt     = CNT_W'(1);
            end
            if (!d.run_val && d.cnt >= CNT_W'(AIC_FALL))
                d.state = 1'b0;
            if (d.run_val && d.cnt >= CNT_W'(AIC_RISE))
                d.state = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign state = q.state;
    assign chg   = d.state ^ q.state;

    p_aic_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(q.state));
    p_aic_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.state) |-> (!$past(q.run_val) && ($past(q.cnt) >= CNT_W'(AIC_FALL - 1))));
    p_aic_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.state) |-> ($past(q.run_val) && ($past(q.cnt) >= CNT_W'(AIC_RISE - 1))));
endmodule

// File: rtl/ds3_level_edge.sv
module ds3_level_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] ev
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t q, d;

    always_comb begin
        d      = q;
        d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign ev[i] = lvl[i] ^ q.prev[i];
    end
endmodule

// File: rtl/ds3_febe_hold.sv
module ds3_febe_hold
    import ds3_alm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  logic       cbit_mode,
    input  logic [2:0] febe_in,
    output logic [2:0] febe_out
);
    typedef struct packed {
        logic [2:0] febe;
    } febe_st_t;

    febe_st_t q, d;

    always_comb begin
        d = q;
        if (stb && cbit_mode) d.febe = febe_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.febe <= FEBE_OK;
        else        q <= d;
    end

    assign febe_out = cbit_mode ? q.febe : FEBE_OK;

    p_febe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cbit_mode |=> $stable(q.febe));
endmodule

// File: rtl/ds3_irq_regs.sv
module ds3_irq_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] ien,
    output logic [W-1:0] isr,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] ien;
        logic [W-1:0] isr;
    } irq_st_t;

    irq_st_t q, d;

    always_comb begin
        d     = q;
        d.isr = (rd ? '0 : q.isr) | (ev & q.ien);
        if (wr) d.ien = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ien = q.ien;
    assign isr = q.isr;
    assign irq = |(q.isr & q.ien);

    p_ien_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q.ien));
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((q.isr & $past(q.isr)) == $past(q.isr)));
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ev == '0) |=> (q.isr == '0));
endmodule

// File: rtl/ds3_rx_alarm_irq.sv
module ds3_rx_alarm_irq
    import ds3_alm_pkg::*;
#(
    parameter int AIC_FALL = 2,
    parameter int AIC_RISE = 63
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cbit_mode,
    input  logic       mframe_stb,
    input  logic       aic_bit,
    input  logic [2:0] febe_bits,
    input  logic       cp_err,
    input  logic       p_err,
    input  logic       los,
    input  logic       ais,
    input  logic       idle,
    input  logic       rdi,
    input  logic       oof,
    input  logic       ien_wr,
    input  logic [7:0] ien_wdata,
    input  logic       isr_rd,
    output logic [7:0] stat_byte,
    output logic [7:0] ien_byte,
    output logic [7:0] isr_byte,
    output logic       irq
);
    logic             aic_state, aic_chg;
    logic [2:0]       febe_view;
    logic [DEF_N-1:0] def_lvl, def_ev;
    logic [IRQ_W-1:0] src_ev;

    ds3_aic_filter #(.AIC_FALL(AIC_FALL), .AIC_RISE(AIC_RISE)) u_aic (
        .clk(clk), .rst_n(rst_n), .stb(mframe_stb), .bit_in(aic_bit),
        .state(aic_state), .chg(aic_chg)
    );

    ds3_febe_hold u_febe (
        .clk(clk), .rst_n(rst_n), .stb(mframe_stb), .cbit_mode(cbit_mode),
        .febe_in(febe_bits), .febe_out(febe_view)
    );

    assign def_lvl = {los, ais, idle, rdi, oof};

    ds3_level_edge #(.N(DEF_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(def_lvl), .ev(def_ev)
    );

    always_comb begin
        src_ev           = '0;
        src_ev[IB_CPERR] = cp_err & cbit_mode;
        src_ev[IB_LOS]   = def_ev[4];
        src_ev[IB_AIS]   = def_ev[3];
        src_ev[IB_IDLE]  = def_ev[2];
        src_ev[IB_RDI]   = def_ev[1];
        src_ev[IB_AIC]   = aic_chg;
        src_ev[IB_OOF]   = def_ev[0];
        src_ev[IB_PERR]  = p_err;
    end

    ds3_irq_regs #(.W(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .ev(src_ev), .wr(ien_wr), .wdata(ien_wdata),
        .rd(isr_rd), .ien(ien_byte), .isr(isr_byte), .irq(irq)
    );

    assign stat_byte = {3'b000, rdi, aic_state, febe_view};

    p_cp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cbit_mode && isr_rd) |=> !isr_byte[IB_CPERR]);
    p_aic_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_byte[IB_AIC] && !ien_wr && ($past(aic_state) != aic_state)) |-> isr_byte[IB_AIC]);
endmodule

// File: tb/sim_ds3_rx_alarm_irq.sv
module sim_ds3_rx_alarm_irq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cbit_mode = 1'b0, mframe_stb = 1'b0, aic_bit = 1'b0;
    logic [2:0] febe_bits = 3'b111;
    logic cp_err = 1'b0, p_err = 1'b0;
    logic los = 1'b0, ais = 1'b0, idle = 1'b0, rdi = 1'b0, oof = 1'b0;
    logic ien_wr = 1'b0, isr_rd = 1'b0;
    logic [7:0] ien_wdata = 8'h00;
    logic [7:0] stat_byte, ien_byte, isr_byte;
    logic irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ds3_rx_alarm_irq u0 (
        .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .mframe_stb(mframe_stb),
        .aic_bit(aic_bit), .febe_bits(febe_bits), .cp_err(cp_err), .p_err(p_err),
        .los(los), .ais(ais), .idle(idle), .rdi(rdi), .oof(oof),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata), .isr_rd(isr_rd),
        .stat_byte(stat_byte), .ien_byte(ien_byte), .isr_byte(isr_byte), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int       m_run = 0;
    bit       m_run_val = 0, m_aic = 0;
    bit [2:0] m_febe = 3'b111;
    bit [4:0] m_prev = 0;
    bit [7:0] m_ien = 0, m_isr = 0;

    always @(posedge clk) begin
        bit [7:0] ev;
        bit [4:0] lv;
        bit       nxt;
        if (!rst_n) begin
            m_run = 0; m_run_val = 0; m_aic = 0; m_febe = 3'b111;
            m_prev = 0; m_ien = 0; m_isr = 0;
        end else begin
            nxt = m_aic;
            if (mframe_stb) begin
                if (aic_bit == m_run_val && m_run > 0) m_run++;
                else begin m_run_val = aic_bit; m_run = 1; end
                if (!m_run_val && m_run >= 2)  nxt = 0;
                if (m_run_val && m_run >= 63)  nxt = 1;
                if (cbit_mode) m_febe = febe_bits;
            end
            lv = {los, ais, idle, rdi, oof};
            ev = 0;
            ev[7] = cp_err & cbit_mode;
            ev[6] = lv[4] ^ m_prev[4];
            ev[5] = lv[3] ^ m_prev[3];
            ev[4] = lv[2] ^ m_prev[2];
            ev[3] = lv[1] ^ m_prev[1];
            ev[2] = nxt ^ m_aic;
            ev[1] = lv[0] ^ m_prev[0];
            ev[0] = p_err;
            m_isr  = (isr_rd ? 8'h00 : m_isr) | (ev & m_ien);
            if (ien_wr) m_ien = ien_wdata;
            m_prev = lv;
            m_aic  = nxt;
        end
        #5;
        if (rst_n && !done) begin
            chk({7'd0, stat_byte[3]}, {7'd0, m_aic}, "R1/R2 model aic");
            chk({5'd0, stat_byte[2:0]}, {5'd0, (cbit_mode ? m_febe : 3'b111)}, "R3 model febe");
            chk({stat_byte[7:5], 4'd0, stat_byte[4]}, {7'd0, rdi}, "R4 model status");
            chk(ien_byte, m_ien, "R8 model enable");
            chk(isr_byte, m_isr, "R5/R6/R7/R9 model flags");
            chk({7'd0, irq}, {7'd0, |(m_isr & m_ien)}, "R10 model irq");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input bit a, input logic [2:0] f);
        @(negedge clk);
        mframe_stb = 1'b1; aic_bit = a; febe_bits = f;
        @(negedge clk);
        mframe_stb = 1'b0;
    endtask

    task automatic frames(input int n, input bit a);
        for (int i = 0; i < n; i++) frame(a, 3'b111);
    endtask

    task automatic wr_ien(input logic [7:0] v);
        @(negedge clk); ien_wr = 1'b1; ien_wdata = v;
        @(negedge clk); ien_wr = 1'b0;
    endtask

    task automatic rd_isr();
        @(negedge clk); isr_rd = 1'b1;
        @(negedge clk); isr_rd = 1'b0;
    endtask

    task automatic set_lvl(input int idx, input bit v);
        case (idx)
            0: los = v;
            1: ais = v;
            2: idle = v;
            3: rdi = v;
            default: oof = v;
        endcase
    endtask

    initial begin
        int pos [5] = '{6, 5, 4, 3, 1};
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(stat_byte, 8'h07, "R11 reset status");
        chk(isr_byte, 8'h00, "R11 reset flags");
        chk(ien_byte, 8'h00, "R8 reset enable");
        chk({7'd0, irq}, 8'h00, "R11 reset irq");

        wr_ien(8'hFF);
        chk(ien_byte, 8'hFF, "R8 enable write");
        cbit_mode = 1'b1;

        frames(62, 1'b1);
        chk({7'd0, stat_byte[3]}, 8'h00, "R2 after 62 ones");
        frames(1, 1'b1);
        chk({7'd0, stat_byte[3]}, 8'h01, "R2 after 63 ones");
        chk(isr_byte, 8'h04, "R7 rise flag");
        chk({7'd0, irq}, 8'h01, "R10 irq on rise");
        rd_isr();
        chk(isr_byte, 8'h00, "R9 read clears");

        frames(1, 1'b0);
        chk({7'd0, stat_byte[3]}, 8'h01, "R1 single zero");
        frames(1, 1'b1);
        frames(1, 1'b0);
        chk({7'd0, stat_byte[3]}, 8'h01, "R1 broken zero run");
        frames(1, 1'b0);
        chk({7'd0, stat_byte[3]}, 8'h00, "R1 two zeros");
        chk(isr_byte, 8'h04, "R7 fall flag");
        rd_isr();

        frames(40, 1'b1);
        frames(1, 1'b0);
        frames(62, 1'b1);
        chk({7'd0, stat_byte[3]}, 8'h00, "R2 restart 62");
        frames(1, 1'b1);
        chk({7'd0, stat_byte[3]}, 8'h01, "R2 restart 63");
        frames(2, 1'b0);
        rd_isr();

        frame(1'b0, 3'b010);
        chk({5'd0, stat_byte[2:0]}, 8'h02, "R3 febe held");
        cbit_mode = 1'b0;
        cyc(1);
        chk({5'd0, stat_byte[2:0]}, 8'h07, "R3 non cbit reads normal");
        frame(1'b0, 3'b001);
        cbit_mode = 1'b1;
        cyc(1);
        chk({5'd0, stat_byte[2:0]}, 8'h02, "R3 non cbit frame ignored");

        for (int i = 0; i < 5; i++) begin
            set_lvl(i, 1'b1);
            cyc(1);
            chk(isr_byte, 8'(1 << pos[i]), "R5 declare edge");
            if (i == 3) chk(stat_byte, 8'h12, "R4 rdi status bit");
            rd_isr();
            set_lvl(i, 1'b0);
            cyc(1);
            chk(isr_byte, 8'(1 << pos[i]), "R5 clear edge");
            rd_isr();
        end

        cbit_mode = 1'b0;
        cp_err = 1'b1; cyc(1); cp_err = 1'b0;
        chk(isr_byte, 8'h00, "R6 cp gated");
        p_err = 1'b1; cyc(1); p_err = 1'b0;
        chk(isr_byte, 8'h01, "R6 p any mode");
        rd_isr();
        cbit_mode = 1'b1;
        cp_err = 1'b1; cyc(1); cp_err = 1'b0;
        chk(isr_byte, 8'h80, "R6 cp in cbit");
        rd_isr();

        wr_ien(8'hDF);
        ais = 1'b1; cyc(1);
        chk(isr_byte, 8'h00, "R8 masked event");
        chk({7'd0, irq}, 8'h00, "R10 masked irq");
        wr_ien(8'hFF);
        ais = 1'b0; cyc(1);
        chk(isr_byte, 8'h20, "R8 unmasked event");
        rd_isr();

        oof = 1'b1; cyc(1);
        chk(isr_byte, 8'h02, "R9 before read");
        isr_rd = 1'b1; p_err = 1'b1;
        cyc(1);
        isr_rd = 1'b0; p_err = 1'b0;
        chk(isr_byte, 8'h01, "R9 event during read kept");
        wr_ien(8'hFE);
        chk({7'd0, irq}, 8'h00, "R10 flag set but disabled");
        chk(isr_byte, 8'h01, "R10 flag remains");
        wr_ien(8'hFF);
        chk({7'd0, irq}, 8'h01, "R10 reenabled");
        rd_isr();

        begin
            bit cur = 1'b0;
            for (int k = 0; k < 6000; k++) begin
                @(negedge clk);
                mframe_stb = ($urandom_range(3) == 0);
                if ($urandom_range(79) == 0) cur = ~cur;
                aic_bit   = ($urandom_range(15) == 0) ? ~cur : cur;
                febe_bits = 3'($urandom_range(7));
                cbit_mode = ($urandom_range(63) != 0) ? cbit_mode : ~cbit_mode;
                cp_err    = ($urandom_range(31) == 0);
                p_err     = ($urandom_range(31) == 0);
                if ($urandom_range(40) == 0) los  = ~los;
                if ($urandom_range(40) == 0) ais  = ~ais;
                if ($urandom_range(40) == 0) idle = ~idle;
                if ($urandom_range(40) == 0) rdi  = ~rdi;
                if ($urandom_range(40) == 0) oof  = ~oof;
                isr_rd    = ($urandom_range(9) == 0);
                ien_wr    = ($urandom_range(99) == 0);
                ien_wdata = 8'($urandom_range(255));
            end
            @(negedge clk);
            mframe_stb = 0; cp_err = 0; p_err = 0; isr_rd = 0; ien_wr = 0;
            cyc(2);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        done = 1'b1;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule